// File: doc/BRIEF.md
# Discrete-Sense Register Slave over SPI

This block is the serial register front end of a 32-channel discrete-input threshold sensor. An external host drives a mode-0 SPI frame: the first byte after chip select goes low is a command whose top bit gives the direction and whose low seven bits give the register address. The width of the data that follows depends on the address. It is 8 bits for the control and sensing-mode registers and for the per-bank sense bytes, 16 bits for the two threshold/hysteresis registers, and 32 bits for the full sense word. All of these stream most significant bit first inside the same frame.

The SPI pins are oversampled by the system clock through a short synchronizer, so all state lives in one clock domain. The block holds the writable registers and drives the test-mode and soft-reset outputs from the control register. The 32-bit parallel sense input is snapshotted when the command byte completes, so a multi-byte read of sense state is coherent.

Top module: `spi_sense_regs`

## Requirements
- R1: A frame starts when `cs_n` falls. Its first byte is the command: bit 7 = 1 reads, bit 7 = 0 writes, and bits 6:0 are the address. Raising `cs_n` ends the frame and discards any incomplete byte, so it has no effect.
- R2: `mosi` is taken on rising `sclk`, and `miso` changes on falling `sclk`. The first read bit appears on the falling edge after the eighth command bit, MSB first. `miso` is 0 while `cs_n` is high and during write frames.
- R3: A read of address 0x78 returns all 32 sense bits as four bytes, channel 31 first.
- R4: Reads of addresses 0x10, 0x12, 0x14 and 0x16 return one sense byte each, for channels 7..0, 15..8, 23..16 and 31..24 respectively.
- R5: The sense input is captured at the end of the command byte. Changes of `sense_in` later in the frame do not alter the bytes returned.
- R6: Address 0x02 is control, with reset value 0x00. Bit 0 drives `test_mode_o` and bit 1 drives `soft_rst_o`. Bits 7:2 read as 0.
- R7: Address 0x04 holds one sensing-mode bit per bank of 8 channels (bit n covers channels 8n..8n+7), with reset value 0x00. Bits 7:4 are not stored and read as 0.
- R8: Addresses 0x3A (ground-open) and 0x3C (supply-open) are 16-bit registers with reset value 0x0206. They are written and read high byte first. A register changes only when its low byte arrives in the same frame, so a frame that carries only the high byte leaves it unchanged.
- R9: While control bit 1 is 1, writes to the mode and threshold registers are ignored. A control write with bit 1 = 0 while bit 1 is 1 returns control, mode and both threshold registers to their reset values.
- R10: A read of an undefined address returns 0x00. Writes to undefined or read-only (sense) addresses change nothing.
- R11: Bytes beyond a register's width within one frame are ignored on write and read as 0x00.
- R12: A synchronous active-high `rst` returns every register to its reset value and drives both control outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI serial clock (mode 0) |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| sense_in | input | 32 | Parallel sense state, one bit per channel |
| soft_rst_o | output | 1 | Soft-reset request (control bit 1) |
| test_mode_o | output | 1 | Test-mode enable (control bit 0) |

## Verification
The bench checks read alignment through the full sense word and the byte-lane reads. A design whose first data bit was one edge late would show every read byte shifted by one bit, and a design that sampled `sense_in` live would return a mixed word when the input changes mid-frame. It also targets the frame edges: a threshold frame carrying only its high byte, extra bytes past the register width, and a frame aborted partway through a data byte. Designs that commit per byte or ignore the byte index fail one of these. Finally, it walks the soft-reset sequence, where a design that honoured writes while held in reset, or failed to restore defaults on release, reads back the wrong mode or threshold values.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    localparam int ADDR_W = 7;

    // Register addresses decoded from the command byte
    localparam logic [ADDR_W-1:0] A_CTRL      = 7'h02;
    localparam logic [ADDR_W-1:0] A_MODE      = 7'h04;
    localparam logic [ADDR_W-1:0] A_SENSE_B0  = 7'h10;
    localparam logic [ADDR_W-1:0] A_SENSE_ALL = 7'h78;
    localparam logic [ADDR_W-1:0] A_THR_GND   = 7'h3A;
    localparam logic [ADDR_W-1:0] A_THR_SUP   = 7'h3C;

    localparam logic [15:0] THR_RST = 16'h0206;

    // Threshold register: high byte hysteresis, low byte centre
    typedef struct packed {
        logic [7:0] hyst;
        logic [7:0] ctr;
    } thr_t;

    typedef struct packed {
        logic srst;
        logic test;
    } ctrl_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CMD,
        PH_WDATA,
        PH_RDATA
    } phase_e;

    function automatic logic is_thr(input logic [ADDR_W-1:0] a);
        return (a == A_THR_GND) || (a == A_THR_SUP);
    endfunction

endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stg
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) st[g] <= RST_VAL;
                else     st[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) st[g] <= RST_VAL;
                else     st[g] <= st[g-1];
            end
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter
    import ssr_pkg::*;
#(
    parameter int TXW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic [TXW-1:0]    rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [1:0]        wr_idx,
    output logic [7:0]        wr_byte,
    output logic              miso
);
    logic              sclk_d;
    logic [2:0]        bit_cnt;
    logic [6:0]        rx_sr;
    phase_e            ph;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        idx_q;
    logic [TXW-1:0]    tx_sr;
    logic              miso_q;

    logic       cs_act, rise, fall, byte_end, cmd_stb;
    logic [7:0] full_byte;

    assign cs_act    = !cs_n_s;
    assign rise      = cs_act && sclk_s && !sclk_d;
    assign fall      = cs_act && !sclk_s && sclk_d;
    assign byte_end  = rise && (bit_cnt == 3'd7);
    assign full_byte = {rx_sr, mosi_s};
    assign cmd_stb   = byte_end && (ph == PH_CMD);

    assign rd_addr = full_byte[6:0];
    assign wr_stb  = byte_end && (ph == PH_WDATA);
    assign wr_addr = addr_q;
    assign wr_idx  = idx_q;
    assign wr_byte = full_byte;
    assign miso    = miso_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d  <= 1'b0;
            bit_cnt <= '0;
            rx_sr   <= '0;
            ph      <= PH_IDLE;
            addr_q  <= '0;
            idx_q   <= '0;
            tx_sr   <= '0;
            miso_q  <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            if (!cs_act) begin
                ph      <= PH_IDLE;
                bit_cnt <= '0;
                idx_q   <= '0;
                miso_q  <= 1'b0;
            end else begin
                if (ph == PH_IDLE) ph <= PH_CMD;
                if (rise) begin
                    rx_sr   <= full_byte[6:0];
                    bit_cnt <= bit_cnt + 3'd1;
                end
                if (cmd_stb) begin
                    addr_q <= full_byte[6:0];
                    ph     <= full_byte[7] ? PH_RDATA : PH_WDATA;
                    if (full_byte[7]) tx_sr <= rd_word;
                end
                if (wr_stb && idx_q != 2'd3) idx_q <= idx_q + 2'd1;
                if (fall) begin
                    if (ph == PH_RDATA) begin
                        miso_q <= tx_sr[TXW-1];
                        tx_sr  <= {tx_sr[TXW-2:0], 1'b0};
                    end else begin
                        miso_q <= 1'b0;
                    end
                end
            end
        end
    end

    // R2
    miso_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> !miso_q);

endmodule

// File: rtl/ssr_regfile.sv
module ssr_regfile
    import ssr_pkg::*;
#(
    parameter int N_CH = 32,
    parameter int TXW  = N_CH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_idx,
    input  logic [7:0]        wr_byte,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [N_CH-1:0]   sense_in,
    output logic [TXW-1:0]    rd_word,
    output logic              soft_rst_o,
    output logic              test_mode_o
);
    localparam int NB = N_CH / 8;

    ctrl_t         ctrl_q;
    logic [NB-1:0] mode_q;
    thr_t          thr_gnd_q, thr_sup_q;
    logic [7:0]    stage_q;

    assign soft_rst_o  = ctrl_q.srst;
    assign test_mode_o = ctrl_q.test;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            mode_q    <= '0;
            thr_gnd_q <= thr_t'(THR_RST);
            thr_sup_q <= thr_t'(THR_RST);
            stage_q   <= '0;
        end else if (wr_stb) begin
            if (wr_addr == A_CTRL) begin
                if (wr_idx == 2'd0) begin
                    if (ctrl_q.srst && !wr_byte[1]) begin
                        ctrl_q    <= '0;
                        mode_q    <= '0;
                        thr_gnd_q <= thr_t'(THR_RST);
                        thr_sup_q <= thr_t'(THR_RST);
                        stage_q   <= '0;
                    end else begin
                        ctrl_q <= ctrl_t'(wr_byte[1:0]);
                    end
                end
            end else if (!ctrl_q.srst) begin
                if (wr_addr == A_MODE && wr_idx == 2'd0)
                    mode_q <= wr_byte[NB-1:0];
                if (is_thr(wr_addr)) begin
                    if (wr_idx == 2'd0) begin
                        stage_q <= wr_byte;
                    end else if (wr_idx == 2'd1) begin
                        if (wr_addr == A_THR_GND) thr_gnd_q <= thr_t'({stage_q, wr_byte});
                        else                      thr_sup_q <= thr_t'({stage_q, wr_byte});
                    end
                end
            end
        end
    end

    always_comb begin
        rd_word = '0;
        case (rd_addr)
            A_CTRL:      rd_word[TXW-1 -: 8]  = {6'b0, ctrl_q};
            A_MODE:      rd_word[TXW-1 -: 8]  = 8'(mode_q);
            A_THR_GND:   rd_word[TXW-1 -: 16] = thr_gnd_q;
            A_THR_SUP:   rd_word[TXW-1 -: 16] = thr_sup_q;
            A_SENSE_ALL: rd_word              = sense_in;
            default:     rd_word              = '0;
        endcase
        for (int i = 0; i < NB; i++) begin
            if (rd_addr == A_SENSE_B0 + 7'(2 * i))
                rd_word[TXW-1 -: 8] = sense_in[8*i +: 8];
        end
    end

    // R9
    srst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_addr == A_MODE && ctrl_q.srst) |=> $stable(mode_q));

    // R8
    thr_partial_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_idx == 2'd0 && wr_addr == A_THR_GND) |=> $stable(thr_gnd_q));

    // R11
    beyond_width_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_idx >= 2'd2) |=> ($stable(thr_gnd_q) && $stable(thr_sup_q)
                                        && $stable(mode_q) && $stable(ctrl_q)));

    // R10
    ro_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_addr == A_SENSE_ALL) |=> ($stable(thr_gnd_q) && $stable(thr_sup_q)
                                               && $stable(mode_q) && $stable(ctrl_q)));

endmodule

// File: rtl/spi_sense_regs.sv
module spi_sense_regs
    import ssr_pkg::*;
#(
    parameter int N_CH        = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sclk,
    input  logic            cs_n,
    input  logic            mosi,
    output logic            miso,
    input  logic [N_CH-1:0] sense_in,
    output logic            soft_rst_o,
    output logic            test_mode_o
);
    localparam int TXW = N_CH;

    logic [2:0]        pins_s;
    logic [TXW-1:0]    rd_word;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic              wr_stb;
    logic [1:0]        wr_idx;
    logic [7:0]        wr_byte;

    ssr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sclk, cs_n, mosi}),
        .q   (pins_s)
    );

    ssr_shifter #(.TXW(TXW)) i_shift (
        .clk     (clk),
        .rst     (rst),
        .sclk_s  (pins_s[2]),
        .cs_n_s  (pins_s[1]),
        .mosi_s  (pins_s[0]),
        .rd_word (rd_word),
        .rd_addr (rd_addr),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_idx  (wr_idx),
        .wr_byte (wr_byte),
        .miso    (miso)
    );

    ssr_regfile #(.N_CH(N_CH), .TXW(TXW)) i_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_stb      (wr_stb),
        .wr_addr     (wr_addr),
        .wr_idx      (wr_idx),
        .wr_byte     (wr_byte),
        .rd_addr     (rd_addr),
        .sense_in    (sense_in),
        .rd_word     (rd_word),
        .soft_rst_o  (soft_rst_o),
        .test_mode_o (test_mode_o)
    );
endmodule

// File: tb/test_spi_sense_regs.sv
module test_spi_sense_regs;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int N_CH       = 32;

    logic            clk = 1'b0;
    logic            rst, sclk, cs_n, mosi;
    logic            miso, soft_rst_o, test_mode_o;
    logic [N_CH-1:0] sense;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_sense_regs #(.N_CH(N_CH)) i_spi_sense_regs (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .sense_in(sense), .soft_rst_o(soft_rst_o),
        .test_mode_o(test_mode_o)
    );

    typedef struct {
        logic [7:0] v;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   mon_on = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expb(input logic [7:0] v, input string req);
        exp_q.push_back('{v, req});
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        mosi = b;
        wait_clk(HALF);
        sclk = 1'b1;
        wait_clk(HALF);
        sclk = 1'b0;
    endtask

    task automatic xfer(input bit rd, input logic [6:0] adr, input int nb,
                        input logic [31:0] wd, input int tail,
                        input bit chg, input logic [31:0] chg_v);
        logic [7:0] c;
        logic [7:0] b;
        c = {rd, adr};
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 7; i >= 0; i--) send_bit(c[i]);
        if (chg) sense = chg_v;
        mon_on = rd;
        for (int k = 0; k < nb; k++) begin
            b = (k < 4) ? wd[31 - 8*k -: 8] : 8'h00;
            for (int i = 7; i >= 0; i--) send_bit(b[i]);
        end
        for (int i = 0; i < tail; i++) send_bit(wd[31 - i]);
        wait_clk(HALF);
        mon_on = 1'b0;
        cs_n = 1'b1;
        wait_clk(4 * HALF);
    endtask

    task automatic rd(input logic [6:0] adr, input int nb);
        xfer(1'b1, adr, nb, 32'h0, 0, 1'b0, 32'h0);
    endtask

    task automatic wr(input logic [6:0] adr, input int nb, input logic [31:0] wd);
        xfer(1'b0, adr, nb, wd, 0, 1'b0, 32'h0);
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // Monitor: assembles read bytes at the host sampling edge and scores them
    initial begin
        logic [7:0] sh;
        int         cnt;
        exp_t       e;
        sh  = '0;
        cnt = 0;
        forever begin
            @(posedge sclk);
            if (!mon_on) begin
                cnt = 0;
            end else begin
                sh = {sh[6:0], miso};
                cnt++;
                if (cnt == 8) begin
                    cnt = 0;
                    n_chk++;
                    if (exp_q.size() == 0) begin
                        n_err++;
                        $display("FAIL R2 unexpected byte actual=%0h expected=none", sh);
                    end else begin
                        e = exp_q.pop_front();
                        if (sh !== e.v) begin
                            n_err++;
                            $display("FAIL %s actual=%0h expected=%0h", e.req, sh, e.v);
                        end
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        report();
        $finish;
    end

    initial begin
        rst = 1'b1; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0; sense = '0;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);

        // R12 reset state at the ports
        chk("R12 soft_rst_o", soft_rst_o, 0);
        chk("R12 test_mode_o", test_mode_o, 0);
        chk("R2 miso idle", miso, 0);
        expb(8'h00, "R6 ctrl reset");   rd(7'h02, 1);
        expb(8'h00, "R7 mode reset");   rd(7'h04, 1);
        expb(8'h02, "R8 gnd reset hi"); expb(8'h06, "R8 gnd reset lo"); rd(7'h3A, 2);
        expb(8'h02, "R8 sup reset hi"); expb(8'h06, "R8 sup reset lo"); rd(7'h3C, 2);

        // R3 full word, channel 31 first; R11 fifth byte zero
        sense = 32'hA5C3_1E78;
        expb(8'hA5, "R3 byte0"); expb(8'hC3, "R3 byte1");
        expb(8'h1E, "R3 byte2"); expb(8'h78, "R3 byte3");
        expb(8'h00, "R11 sense beyond");
        rd(7'h78, 5);

        // R4 byte lanes
        expb(8'h78, "R4 ch7..0");   rd(7'h10, 1);
        expb(8'h1E, "R4 ch15..8");  rd(7'h12, 1);
        expb(8'hC3, "R4 ch23..16"); rd(7'h14, 1);
        expb(8'hA5, "R4 ch31..24"); rd(7'h16, 1);

        // R5 snapshot at end of command byte
        sense = 32'h1234_5678;
        expb(8'h12, "R5 snap0"); expb(8'h34, "R5 snap1");
        expb(8'h56, "R5 snap2"); expb(8'h78, "R5 snap3");
        xfer(1'b1, 7'h78, 4, 32'h0, 0, 1'b1, 32'hFFFF_FFFF);
        expb(8'hFF, "R5 new value"); rd(7'h16, 1);
        sense = 32'hA5C3_1E78;

        // R6 control
        wr(7'h02, 1, 32'h0100_0000);
        chk("R6 test_mode_o", test_mode_o, 1);
        chk("R6 soft_rst_o", soft_rst_o, 0);
        expb(8'h01, "R6 ctrl readback"); expb(8'h00, "R11 ctrl beyond"); rd(7'h02, 2);

        // R7 sensing mode
        wr(7'h04, 1, 32'hFF00_0000);
        expb(8'h0F, "R7 upper bits"); rd(7'h04, 1);
        wr(7'h04, 1, 32'h0A00_0000);
        expb(8'h0A, "R7 mode value"); rd(7'h04, 1);

        // R1 aborted frame mid data byte
        xfer(1'b0, 7'h04, 0, 32'hF000_0000, 4, 1'b0, 32'h0);
        expb(8'h0A, "R1 aborted byte"); rd(7'h04, 1);
        chk("R2 miso write frame", miso, 0);

        // R8 thresholds
        wr(7'h3A, 2, 32'h040C_0000);
        expb(8'h04, "R8 gnd hi"); expb(8'h0C, "R8 gnd lo"); rd(7'h3A, 2);
        expb(8'h02, "R8 sup untouched hi"); expb(8'h06, "R8 sup untouched lo"); rd(7'h3C, 2);
        wr(7'h3C, 3, 32'h0610_5500);
        expb(8'h06, "R8 sup hi"); expb(8'h10, "R8 sup lo");
        expb(8'h00, "R11 thr beyond"); rd(7'h3C, 3);
        wr(7'h3A, 1, 32'h0800_0000);
        expb(8'h04, "R8 partial hi"); expb(8'h0C, "R8 partial lo"); rd(7'h3A, 2);

        // R10 undefined and read-only addresses
        expb(8'h00, "R10 undef0"); expb(8'h00, "R10 undef1"); rd(7'h20, 2);
        wr(7'h20, 1, 32'hFF00_0000);
        wr(7'h10, 1, 32'hFF00_0000);
        wr(7'h78, 4, 32'hFFFF_FFFF);
        expb(8'h78, "R10 ro sense"); rd(7'h10, 1);
        expb(8'h0A, "R10 mode kept"); rd(7'h04, 1);
        expb(8'h01, "R10 ctrl kept"); rd(7'h02, 1);

        // R9 soft reset sequence
        wr(7'h02, 1, 32'h0300_0000);
        chk("R9 soft_rst_o set", soft_rst_o, 1);
        wr(7'h04, 1, 32'h0500_0000);
        expb(8'h0A, "R9 write held off"); rd(7'h04, 1);
        wr(7'h02, 1, 32'h0000_0000);
        chk("R9 soft_rst_o clear", soft_rst_o, 0);
        chk("R9 test_mode_o clear", test_mode_o, 0);
        expb(8'h00, "R9 ctrl default"); rd(7'h02, 1);
        expb(8'h00, "R9 mode default"); rd(7'h04, 1);
        expb(8'h02, "R9 gnd hi"); expb(8'h06, "R9 gnd lo"); rd(7'h3A, 2);
        expb(8'h02, "R9 sup hi"); expb(8'h06, "R9 sup lo"); rd(7'h3C, 2);

        // R12 hard reset
        wr(7'h04, 1, 32'h0300_0000);
        wr(7'h02, 1, 32'h0100_0000);
        rst = 1'b1;
        wait_clk(3);
        rst = 1'b0;
        wait_clk(5);
        chk("R12 test_mode_o after rst", test_mode_o, 0);
        expb(8'h00, "R12 mode after rst"); rd(7'h04, 1);

        chk("R2 all expected bytes seen", exp_q.size(), 0);
        report();
        $finish;
    end
endmodule